// File: doc/BRIEF.md
# Commit-Protected Pin Function Select Register

This block holds the per-pin mode selection for one eight-line general-purpose I/O port. Each select bit decides who drives the pin. A 0 leaves the pin under the software GPIO logic. A 1 hands the pin to its peripheral function. The eight select bits go straight to the pin multiplexer.

Some pins carry the debug interface. A stray software write must not take those pins away from the debugger. So the select bits for those pins are protected, and a write changes one of them only when two conditions hold. First, a key register must be unlocked by writing a fixed 32-bit key. Second, the matching bit in a commit-enable register must be 1. The commit-enable register can only be changed while the key register is unlocked. A single parameter mask does two jobs: it marks the protected pins, and it marks the pins that come out of reset in peripheral mode.

Software reaches the three registers over a simple single-cycle bus. A write is taken on the clock edge in which the strobe is high. Reads are combinational and follow the address. Power-on reset and the external reset pin are combined outside this block into the one active-low reset input.

Top module: `pin_func_select`

## Requirements
- R1: After reset, the select register (offset 0x420) reads the protect mask (default 0x0F), and `pin_periph_sel` equals that mask. Protected pins come out of reset in peripheral mode; every other pin comes out in GPIO mode.
- R2: A write to offset 0x420 stores data bits for unprotected pins directly, whether the key register is locked or unlocked.
- R3: While the key register is locked, a write to offset 0x420 leaves every protected select bit unchanged.
- R4: While the key register is unlocked, a write to offset 0x420 updates a protected select bit only if its commit-enable bit is 1. A protected bit whose commit-enable bit is 0 keeps its value.
- R5: The key register sits at offset 0x520 and reads 1 in bit 0 when locked and 0 when unlocked. Writing 0x6B1D93E4 unlocks it. A write of any other value locks it. Reset leaves it locked.
- R6: The commit-enable register sits at offset 0x524 and resets to the inverse of the protect mask (default 0xF0). While the key register is locked, writes to it are ignored.
- R7: Bits 31:8 of the select register and of the commit-enable register read zero. Writes to those bits have no effect.
- R8: A write becomes visible on the clock edge that samples the strobe. Before that edge, `pin_periph_sel` still shows the old value. Read data follows `bus_addr` combinationally in the same cycle.
- R9: A read of any other offset returns zero. A write to any other offset changes no register.
- R10: Asserting reset after the registers have been changed restores the select, key and commit-enable registers to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on and external reset combined) |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 12 | Byte offset within the port register space |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_periph_sel | output | 8 | Per-pin select to the pin multiplexer (1 = peripheral) |

## Verification
The bench writes mixed patterns that touch protected and unprotected bits in the same word, in every lock and commit state.

- If a design gated the whole word, unprotected bits would freeze while locked.
- If a design ignored the commit-enable bit, it would let protected pins change after an unlock.

The bench also checks three more cases:

- A wrong key must relock a part that is already unlocked. A design that only ever set the unlock flag would stay open.
- Commit-enable writes while locked must be ignored. A design that got this wrong would let software arm a protected bit without the key.
- Reserved upper bits and unmapped offsets must read zero. A design that decoded too loosely would echo data or alias the select register.

Each step is sampled just before and just after the write edge, which catches a write that lands a cycle early or a cycle late.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    localparam int unsigned PFS_ADDR_W = 12;
    localparam int unsigned PFS_DATA_W = 32;

    // Register offsets inside the port space
    localparam logic [PFS_ADDR_W-1:0] OFS_SELECT = 12'h420;
    localparam logic [PFS_ADDR_W-1:0] OFS_KEY    = 12'h520;
    localparam logic [PFS_ADDR_W-1:0] OFS_COMMIT = 12'h524;

    typedef enum logic [1:0] {
        SLOT_NONE   = 2'd0,
        SLOT_SELECT = 2'd1,
        SLOT_KEY    = 2'd2,
        SLOT_COMMIT = 2'd3
    } pfs_slot_e;

    function automatic pfs_slot_e pfs_decode(input logic [PFS_ADDR_W-1:0] a);
        pfs_slot_e s;
        s = SLOT_NONE;
        if (a == OFS_SELECT) begin
            s = SLOT_SELECT;
        end else if (a == OFS_KEY) begin
            s = SLOT_KEY;
        end else if (a == OFS_COMMIT) begin
            s = SLOT_COMMIT;
        end
        return s;
    endfunction

endpackage

// File: rtl/pfs_keyguard.sv
module pfs_keyguard #(
    parameter int unsigned          DATA_W = 32,
    parameter logic [DATA_W-1:0]    KEY    = 32'h6B1D_93E4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_key,
    input  logic [DATA_W-1:0] wdata,
    output logic              unlocked
);

    typedef struct packed {
        logic open;
    } guard_t;

    guard_t guard_d, guard_q;

    always_comb begin
        guard_d = guard_q;
        if (wr_key) begin
            guard_d.open = (wdata == KEY);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            guard_q <= '0;
        end else begin
            guard_q <= guard_d;
        end
    end

    assign unlocked = guard_q.open;

    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_key && wdata == KEY) |=> unlocked) else $error("key did not unlock"); // R5

    AST_KEY_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_key && wdata != KEY) |=> !unlocked) else $error("bad key left unlocked"); // R5

    AST_KEY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_key |=> $stable(unlocked)) else $error("lock changed without write"); // R5

endmodule

// File: rtl/pfs_commit.sv
module pfs_commit #(
    parameter int unsigned         NPINS     = 8,
    parameter logic [NPINS-1:0]    PROT_MASK = 8'h0F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_commit,
    input  logic             unlocked,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] commit_en
);

    localparam logic [NPINS-1:0] RESET_VAL = ~PROT_MASK;

    typedef struct packed {
        logic [NPINS-1:0] en;
    } commit_t;

    commit_t commit_d, commit_q;

    always_comb begin
        commit_d = commit_q;
        if (wr_commit && unlocked) begin
            commit_d.en = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            commit_q.en <= RESET_VAL;
        end else begin
            commit_q <= commit_d;
        end
    end

    assign commit_en = commit_q.en;

    AST_COMMIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(commit_en)) else $error("commit-enable moved while locked"); // R6

endmodule

// File: rtl/pfs_selreg.sv
module pfs_selreg #(
    parameter int unsigned         NPINS     = 8,
    parameter logic [NPINS-1:0]    PROT_MASK = 8'h0F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_select,
    input  logic             unlocked,
    input  logic [NPINS-1:0] commit_en,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] select
);

    typedef struct packed {
        logic [NPINS-1:0] bits;
    } sel_t;

    sel_t sel_d, sel_q;
    logic [NPINS-1:0] bit_allow;

    // Per-bit write permission: open bits always, guarded bits need key + commit
    for (genvar i = 0; i < NPINS; i++) begin : g_allow
        if (PROT_MASK[i]) begin : g_guarded
            assign bit_allow[i] = unlocked & commit_en[i];
        end else begin : g_open
            assign bit_allow[i] = 1'b1;
        end
    end

    always_comb begin
        sel_d = sel_q;
        if (wr_select) begin
            for (int i = 0; i < NPINS; i++) begin
                if (bit_allow[i]) begin
                    sel_d.bits[i] = wdata[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q.bits <= PROT_MASK;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign select = sel_q.bits;

    AST_OPEN_BITS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_select |=> ((select & ~PROT_MASK) == ($past(wdata) & ~PROT_MASK)))
        else $error("unprotected bits not written"); // R2

    AST_GUARD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_select && !unlocked) |=> ((select & PROT_MASK) == ($past(select) & PROT_MASK)))
        else $error("protected bits moved while locked"); // R3

    AST_GUARD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_select |=> ((select & PROT_MASK & ~$past(commit_en)) ==
                       ($past(select) & PROT_MASK & ~$past(commit_en))))
        else $error("uncommitted protected bit moved"); // R4

endmodule

// File: rtl/pin_func_select.sv
module pin_func_select #(
    parameter int unsigned                      NPINS     = 8,
    parameter logic [NPINS-1:0]                 PROT_MASK = 8'h0F,
    parameter logic [pfs_pkg::PFS_DATA_W-1:0]   KEY       = 32'h6B1D_93E4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_wr,
    input  logic [pfs_pkg::PFS_ADDR_W-1:0]    bus_addr,
    input  logic [pfs_pkg::PFS_DATA_W-1:0]    bus_wdata,
    output logic [pfs_pkg::PFS_DATA_W-1:0]    bus_rdata,
    output logic [NPINS-1:0]                  pin_periph_sel
);
    import pfs_pkg::*;

    localparam int unsigned DATA_W = PFS_DATA_W;
    localparam int unsigned PAD_W  = DATA_W - NPINS;

    pfs_slot_e        slot;
    logic             wr_select, wr_key, wr_commit;
    logic             unlocked;
    logic [NPINS-1:0] commit_en;
    logic [NPINS-1:0] select;

    always_comb begin
        slot      = pfs_decode(bus_addr);
        wr_select = bus_wr && (slot == SLOT_SELECT);
        wr_key    = bus_wr && (slot == SLOT_KEY);
        wr_commit = bus_wr && (slot == SLOT_COMMIT);
    end

    pfs_keyguard #(
        .DATA_W (DATA_W),
        .KEY    (KEY)
    ) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_key   (wr_key),
        .wdata    (bus_wdata),
        .unlocked (unlocked)
    );

    pfs_commit #(
        .NPINS     (NPINS),
        .PROT_MASK (PROT_MASK)
    ) u_commit (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_commit (wr_commit),
        .unlocked  (unlocked),
        .wdata     (bus_wdata[NPINS-1:0]),
        .commit_en (commit_en)
    );

    pfs_selreg #(
        .NPINS     (NPINS),
        .PROT_MASK (PROT_MASK)
    ) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_select (wr_select),
        .unlocked  (unlocked),
        .commit_en (commit_en),
        .wdata     (bus_wdata[NPINS-1:0]),
        .select    (select)
    );

    always_comb begin
        unique case (slot)
            SLOT_SELECT: bus_rdata = {{PAD_W{1'b0}}, select};
            SLOT_KEY:    bus_rdata = {{(DATA_W-1){1'b0}}, ~unlocked};
            SLOT_COMMIT: bus_rdata = {{PAD_W{1'b0}}, commit_en};
            default:     bus_rdata = '0;
        endcase
    end

    assign pin_periph_sel = select;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (slot != SLOT_KEY) |-> (bus_rdata[DATA_W-1:NPINS] == '0))
        else $error("reserved bits not zero"); // R7

    AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && slot == SLOT_NONE) |=>
            ($stable(pin_periph_sel) && $stable(unlocked) && $stable(commit_en)))
        else $error("unmapped write changed state"); // R9

endmodule

// File: tb/pin_func_select_test.sv
module pin_func_select_test;

    localparam int          CLK_PERIOD = 10;
    localparam logic [7:0]  PMASK      = 8'h0F;
    localparam logic [31:0] KEYV       = 32'h6B1D_93E4;
    localparam logic [11:0] A_SEL      = 12'h420;
    localparam logic [11:0] A_KEY      = 12'h520;
    localparam logic [11:0] A_CMT      = 12'h524;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_periph_sel;

    pin_func_select uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_wr         (bus_wr),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .pin_periph_sel (pin_periph_sel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [31:0] exp_rd;
        logic [7:0]  exp_pin;
        string       tag;
    } item_t;

    item_t q[$];
    int n_chk = 0;
    int n_bad = 0;

    // reference state, updated from the requirement rules
    logic [7:0] m_sel;
    logic [7:0] m_cmt;
    logic       m_open;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_sel  = PMASK;
        m_cmt  = ~PMASK;
        m_open = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        #1;
        check({24'h0, pin_periph_sel}, {24'h0, m_sel}, "R8 pins before edge");
        if (a == A_SEL) begin
            for (int i = 0; i < 8; i++) begin
                if (!PMASK[i] || (m_open && m_cmt[i])) m_sel[i] = d[i];
            end
        end else if (a == A_KEY) begin
            m_open = (d == KEYV);
        end else if (a == A_CMT) begin
            if (m_open) m_cmt = d[7:0];
        end
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        item_t it;
        logic [31:0] e;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_addr  = a;
        bus_wdata = '0;
        if (a == A_SEL)      e = {24'h0, m_sel};
        else if (a == A_KEY) e = {31'h0, ~m_open};
        else if (a == A_CMT) e = {24'h0, m_cmt};
        else                 e = '0;
        #1;
        check(bus_rdata, e, {tag, " same-cycle read (R8)"});
        it.exp_rd  = e;
        it.exp_pin = m_sel;
        it.tag     = tag;
        q.push_back(it);
    endtask

    // monitor: pops scoreboard items just after the edge
    always @(posedge clk) begin
        #1;
        if (q.size() != 0) begin
            item_t it;
            it = q.pop_front();
            check(bus_rdata, it.exp_rd, it.tag);
            check({24'h0, pin_periph_sel}, {24'h0, it.exp_pin}, {it.tag, " pins"});
        end
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R5 / R6 reset values
        rd(A_SEL, "R1 select reset");
        rd(A_KEY, "R5 key reset locked");
        rd(A_CMT, "R6 commit reset");

        // R2 / R3 locked writes
        wr(A_SEL, 32'h0000_0030);
        rd(A_SEL, "R2 R3 locked mixed write");
        wr(A_SEL, 32'h0000_0000);
        rd(A_SEL, "R3 protected held while locked");

        // R6 commit ignored while locked
        wr(A_CMT, 32'h0000_00FF);
        rd(A_CMT, "R6 commit write while locked");

        // R5 key handling
        wr(A_KEY, 32'h1234_5678);
        rd(A_KEY, "R5 wrong key stays locked");
        wr(A_KEY, KEYV);
        rd(A_KEY, "R5 key unlocks");

        // R4 unlocked, commit bits still 0
        wr(A_SEL, 32'h0000_0000);
        rd(A_SEL, "R4 unlocked without commit");

        // R4 partial commit
        wr(A_CMT, 32'h0000_0005);
        rd(A_CMT, "R6 commit write while unlocked");
        wr(A_SEL, 32'h0000_00A0);
        rd(A_SEL, "R4 partial commit");

        // R7 reserved bits
        wr(A_SEL, 32'hFFFF_FF01);
        rd(A_SEL, "R7 select reserved bits");
        wr(A_CMT, 32'hFFFF_FF05);
        rd(A_CMT, "R7 commit reserved bits");

        // R5 relock by a bad key, then R3 again
        wr(A_KEY, 32'h0000_0000);
        rd(A_KEY, "R5 bad key relocks");
        wr(A_SEL, 32'h0000_00F0);
        rd(A_SEL, "R2 R3 after relock");

        // R9 unmapped offset
        wr(12'h424, 32'hFFFF_FFFF);
        rd(12'h424, "R9 unmapped read");
        rd(A_SEL, "R9 select untouched");
        rd(A_KEY, "R9 key untouched");
        rd(A_CMT, "R9 commit untouched");

        // R10 reset restores defaults
        @(negedge clk);
        bus_wr = 1'b0;
        rst_n  = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        rd(A_SEL, "R10 select after reset");
        rd(A_KEY, "R10 key after reset");
        rd(A_CMT, "R10 commit after reset");

        repeat (3) @(negedge clk);
        summary();
    end

endmodule